// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a synchronous word-request port and a 16-bit extended-data-out DRAM that has a 9-bit multiplexed address bus. Each request carries a write flag, two byte enables, an 18-bit word address and 16 bits of write data. The controller puts the row half of the address on the shared bus when the row strobe falls. It puts the column half on the bus when a column strobe falls. Two column strobes act as byte lanes: one for the low byte and one for the high byte.

After an access the row is left open. A later request to the same row needs only a column cycle (fast page mode). The row is closed by precharge when a request targets another row, when refresh is requested, or when the row-strobe low time nears its limit. Writes are early writes: the write strobe goes low together with the column strobe, and the controller drives the data bus only during that window. Read data is taken in one cycle after the column strobe rises, which relies on the extended data hold. It is returned with a one-cycle valid pulse. Refresh is started from outside through a request input and is carried out as a column-before-row refresh.

All timing values are given in clock cycles through parameters.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the row strobe, both column strobes, the write strobe and the output-enable strobe are high, `dram_dq_oe` is low and `rd_valid` is low.
- R2: On a row-strobe falling edge for an access, `dram_addr` carries `req_addr[17:9]` (the row). On the column-strobe falling edge it carries `req_addr[8:0]` (the column). Data written to one {row, column} is read back from the same pair.
- R3: `dram_cas_n[0]` strobes data bits 7:0 and `dram_cas_n[1]` strobes bits 15:8. `req_be[i]` selects lane i. On a write, a lane that is not selected keeps its stored value.
- R4: On a write, the write strobe is low in the cycle the column strobe falls and stays steady while the column strobe is low. The output-enable strobe is high at that time.
- R5: A request whose row equals the open row is served with a column cycle only, with no new row-strobe fall.
- R6: A request to another row precharges first. Before every row-strobe fall, the row strobe has been high for at least T_RP cycles.
- R7: The row strobe never stays low for more than RAS_MAX_CYC consecutive cycles. An open row that is left idle is closed by the controller itself.
- R8: When `ref_req` is asserted, any open row is closed. Both column strobes then fall while the row strobe is high, with the write strobe high. The row strobe then falls, and `ref_done` pulses for one cycle as the refresh ends.
- R9: Every read produces exactly one `rd_valid` pulse of one cycle. `rd_data` holds the word that was taken in after the column strobe rose, with the bits of lanes that were not selected forced to zero.
- R10: The column strobe stays low for at least T_CAS cycles. The first column-strobe fall in a row comes at least T_RCD cycles after the row-strobe fall.
- R11: `dram_dq_oe` is high only while a column strobe is low in a write cycle. At all other times the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | High in the cycle the presented request is taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read data |
| rd_data | output | 16 | Read data, lanes not selected are zero |
| ref_req | input | 1 | Refresh request, held until ref_done |
| ref_done | output | 1 | One-cycle pulse at the end of a refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes, bit 0 low byte, bit 1 high byte |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
The hardest case to reach is the forced close when the row-strobe low time runs out. In normal use a row stays open only while hits keep arriving, and the limit is many thousands of cycles. The bench therefore builds the block with a 40-cycle limit. It then streams a run of same-row reads long enough to reach the limit in the middle of a page, and it also leaves an opened row idle. A behavioural memory in the bench measures every strobe high and low run, so both the forced close and the reopening of the row are visible at the pins.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    ST_CLOSED,
    ST_ROW,
    ST_CAS,
    ST_CP,
    ST_OPEN,
    ST_PRE,
    ST_RF_CAS,
    ST_RF_RAS
  } edo_state_t;

  localparam int LANE_BITS = 8;
endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign done = (remain == '0);
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int RW       = 9,
  parameter int CW       = 15,
  parameter int CLOSE_AT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_low,
  input  logic          open_ld,
  input  logic [RW-1:0] row_in,
  output logic          row_hit,
  output logic          at_limit,
  output logic [CW-1:0] ras_cnt
);
  logic [RW-1:0] open_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row <= '0;
      ras_cnt  <= '0;
    end else begin
      if (open_ld) open_row <= row_in;
      ras_cnt <= ras_low ? ras_cnt + 1'b1 : '0;
    end
  end

  assign row_hit  = (open_row == row_in);
  assign at_limit = (ras_cnt >= CW'(CLOSE_AT));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int AW          = 9,
  parameter int DW          = 16,
  parameter int T_RCD       = 4,
  parameter int T_CAS       = 2,
  parameter int T_CP        = 2,
  parameter int T_RP        = 8,
  parameter int T_CSR       = 2,
  parameter int T_RFR       = 8,
  parameter int RAS_MAX_CYC = 20000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [1:0]      req_be,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            ref_req,
  output logic            ref_done,
  output logic            dram_ras_n,
  output logic [1:0]      dram_cas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [AW-1:0]   dram_addr,
  output logic [DW-1:0]   dram_dq_out,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_in
);
  localparam int LANES    = DW / LANE_BITS;
  localparam int TW       = $clog2(T_RCD + T_CAS + T_CP + T_RP + T_CSR + T_RFR + 1);
  localparam int RAS_CW   = $clog2(RAS_MAX_CYC + 1);
  localparam int CLOSE_AT = RAS_MAX_CYC - T_CAS - T_CP - 1;

  function automatic logic [AW-1:0] row_of(input logic [2*AW-1:0] a);
    return a[2*AW-1:AW];
  endfunction

  function automatic logic [AW-1:0] col_of(input logic [2*AW-1:0] a);
    return a[AW-1:0];
  endfunction

  function automatic logic [TW-1:0] dwell(input edo_state_t s);
    case (s)
      ST_ROW:    return TW'(T_RCD - 1);
      ST_CAS:    return TW'(T_CAS - 1);
      ST_CP:     return TW'(T_CP - 1);
      ST_PRE:    return TW'(T_RP - 1);
      ST_RF_CAS: return TW'(T_CSR - 1);
      ST_RF_RAS: return TW'(T_RFR - 1);
      default:   return '0;
    endcase
  endfunction

  edo_state_t state, nxt;
  logic take, tmr_done, row_hit, at_limit, ras_low, cas_end, refresh_cas, cap_pend;
  logic [RAS_CW-1:0] ras_cnt;
  logic cur_write;
  logic [1:0] cur_be;
  logic [2*AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata, lane_mask;

  edo_cycle_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (nxt != state),
    .load_val (dwell(nxt)),
    .done     (tmr_done)
  );

  edo_row_tracker #(.RW(AW), .CW(RAS_CW), .CLOSE_AT(CLOSE_AT)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_low  (ras_low),
    .open_ld  (take && state == ST_CLOSED),
    .row_in   (row_of(req_addr)),
    .row_hit  (row_hit),
    .at_limit (at_limit),
    .ras_cnt  (ras_cnt)
  );

  always_comb begin
    nxt      = state;
    take     = 1'b0;
    ref_done = 1'b0;
    unique case (state)
      ST_CLOSED: begin
        if (ref_req) nxt = ST_RF_CAS;
        else if (req_valid) begin
          take = 1'b1;
          nxt  = ST_ROW;
        end
      end
      ST_ROW: if (tmr_done) nxt = ST_CAS;
      ST_CAS: if (tmr_done) nxt = ST_CP;
      ST_CP:  if (tmr_done) nxt = ST_OPEN;
      ST_OPEN: begin
        if (ref_req || at_limit) nxt = ST_PRE;
        else if (req_valid) begin
          if (row_hit) begin
            take = 1'b1;
            nxt  = ST_CAS;
          end else begin
            nxt = ST_PRE;
          end
        end
      end
      ST_PRE:    if (tmr_done) nxt = ST_CLOSED;
      ST_RF_CAS: if (tmr_done) nxt = ST_RF_RAS;
      ST_RF_RAS: begin
        if (tmr_done) begin
          nxt      = ST_PRE;
          ref_done = 1'b1;
        end
      end
      default: nxt = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CLOSED;
      cur_write <= 1'b0;
      cur_be    <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      state <= nxt;
      if (take) begin
        cur_write <= req_write;
        cur_be    <= req_be;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
    end
  end

  assign req_ready   = take;
  assign ras_low     = (state inside {ST_ROW, ST_CAS, ST_CP, ST_OPEN, ST_RF_RAS});
  assign refresh_cas = (state inside {ST_RF_CAS, ST_RF_RAS});
  assign cas_end     = (state == ST_CAS) && tmr_done;

  assign dram_ras_n  = !ras_low;
  assign dram_we_n   = !(state == ST_CAS && cur_write);
  assign dram_oe_n   = !((state inside {ST_CAS, ST_CP}) && !cur_write);
  assign dram_addr   = (state == ST_ROW) ? row_of(cur_addr) : col_of(cur_addr);
  assign dram_dq_out = cur_wdata;
  assign dram_dq_oe  = (state == ST_CAS) && cur_write;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dram_cas_n[g] = !((state == ST_CAS && cur_be[g]) || refresh_cas);
    assign lane_mask[g*LANE_BITS +: LANE_BITS] = {LANE_BITS{cur_be[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pend <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      cap_pend <= cas_end && !cur_write;
      rd_valid <= cap_pend;
      if (cap_pend) rd_data <= dram_dq_in & lane_mask;
    end
  end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int T_CAS       = 2,
  parameter int T_RP        = 8,
  parameter int RAS_MAX_CYC = 20000,
  parameter int RAS_CW      = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic [1:0]        cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic              ref_done,
  input logic [RAS_CW-1:0] ras_cnt
);
  logic [7:0] cas_lo_run, ras_hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_lo_run <= '0;
      ras_hi_run <= 8'(T_RP);
    end else begin
      if (cas_n == 2'b11) cas_lo_run <= '0;
      else if (cas_lo_run != 8'hFF) cas_lo_run <= cas_lo_run + 1'b1;
      if (!ras_n) ras_hi_run <= '0;
      else if (ras_hi_run != 8'hFF) ras_hi_run <= ras_hi_run + 1'b1;
    end
  end

  a_r1_quiet_out_of_reset: assert property (@(posedge clk)
    !rst_n |=> (ras_n && cas_n == 2'b11 && we_n && oe_n && !dq_oe && !rd_valid));

  a_r4_we_steady_under_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 2'b11 && $past(cas_n) != 2'b11 && !ras_n) |-> $stable(we_n));

  a_r4_oe_off_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  a_r6_precharge_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (int'(ras_hi_run) >= T_RP));

  a_r7_ras_window: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ras_cnt) < RAS_MAX_CYC);

  a_r8_refresh_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n != 2'b11) |-> (cas_n == 2'b00 && we_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r10_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n == 2'b11 && $past(cas_n) != 2'b11) |-> (int'(cas_lo_run) >= T_CAS));

  a_r11_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && cas_n != 2'b11 && !ras_n));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .T_CAS       (T_CAS),
  .T_RP        (T_RP),
  .RAS_MAX_CYC (RAS_MAX_CYC),
  .RAS_CW      (RAS_CW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (dram_ras_n),
  .cas_n    (dram_cas_n),
  .we_n     (dram_we_n),
  .oe_n     (dram_oe_n),
  .dq_oe    (dram_dq_oe),
  .rd_valid (rd_valid),
  .ref_done (ref_done),
  .ras_cnt  (ras_cnt)
);

// File: tb/edo_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb_top;
  localparam int T_RCD   = 4;
  localparam int T_CAS   = 2;
  localparam int T_RP    = 8;
  localparam int RAS_MAX = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [1:0] req_be = 2'b00;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_done, ras_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out;
  logic [1:0] cas_n;
  logic [8:0] addr;
  logic [15:0] m_dq = '0;

  int n_chk = 0, n_fail = 0;
  int ras_falls = 0, refreshes = 0, hi_run = 100, lo_run = 0, cas_run = 0;

  always #2.5 clk = ~clk;

  edo_dram_ctrl #(.RAS_MAX_CYC(RAS_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_done(ref_done),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(m_dq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural memory and pin monitor
  logic [15:0] mem [int];
  logic [8:0] m_row = '0;
  logic p_ras = 1'b1;
  logic [1:0] p_cas = 2'b11;
  bit cbr_armed = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_n) begin
        if (!p_ras) chk(lo_run <= RAS_MAX, "R7 ras low run", lo_run, RAS_MAX);
        hi_run++;
      end else begin
        if (p_ras) begin
          ras_falls++;
          chk(hi_run >= T_RP, "R6 precharge run", hi_run, T_RP);
          if (cas_n != 2'b11) begin
            chk(cbr_armed && cas_n == 2'b00, "R8 column before row", {30'd0, cas_n}, 0);
            refreshes++;
          end else begin
            m_row = addr;
          end
          lo_run = 0;
          hi_run = 0;
        end
        lo_run++;
      end
      if (cas_n == 2'b11) begin
        if (p_cas != 2'b11) chk(cas_run >= T_CAS, "R10 cas low width", cas_run, T_CAS);
        cas_run = 0;
        cbr_armed = 1'b0;
      end else begin
        cas_run++;
      end
      if (p_cas == 2'b11 && cas_n != 2'b11) begin
        if (ras_n) begin
          cbr_armed = 1'b1;
          chk(we_n, "R8 write strobe high in refresh", {31'd0, we_n}, 1);
        end else begin
          int key;
          key = int'({m_row, addr});
          if (p_ras == 1'b0 && lo_run == T_RCD + 1)
            chk(1'b1, "R10 row to column", lo_run, T_RCD + 1);
          chk(lo_run > T_RCD, "R10 row to column", lo_run, T_RCD + 1);
          if (!we_n) begin
            logic [15:0] old;
            chk(oe_n && dq_oe, "R4 early write", {30'd0, oe_n, dq_oe}, 3);
            old = mem.exists(key) ? mem[key] : 16'h0000;
            if (!cas_n[0]) old[7:0] = dq_out[7:0];
            if (!cas_n[1]) old[15:8] = dq_out[15:8];
            mem[key] = old;
          end else begin
            chk(!dq_oe, "R11 bus released on read", {31'd0, dq_oe}, 0);
            m_dq = mem.exists(key) ? mem[key] : 16'hDEAD;
          end
        end
      end
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  function automatic logic [17:0] mk_addr(input int r, input int c);
    logic [8:0] rr, cc;
    rr = 9'((r * 171) % 512);
    cc = 9'((c * 73 + 5) % 512);
    return {rr, cc};
  endfunction

  function automatic logic [15:0] pat(input logic [17:0] a, input logic [15:0] salt);
    return 16'((32'(a) * 32'h9E37) ^ 32'(salt));
  endfunction

  task automatic access(input bit wr, input logic [1:0] be, input logic [17:0] a,
                        input logic [15:0] wd, output logic [15:0] rd);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = wd;
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) chk(1'b0, "R2 request not taken", 0, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    rd = '0;
    if (!wr) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!rd_valid && n < 1000);
      if (!rd_valid) chk(1'b0, "R9 no read valid", 0, 1);
      rd = rd_data;
      @(negedge clk);
      chk(!rd_valid, "R9 valid is one pulse", {31'd0, rd_valid}, 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd, expv, nv;
    int falls0, refs0, hits;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n == 2'b11 && we_n && oe_n, "R1 strobes high in reset",
        {28'd0, ras_n, cas_n, we_n}, 32'hF);
    chk(!dq_oe && !rd_valid, "R1 bus off in reset", {30'd0, dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && !dq_oe, "R1 strobes high after reset",
        {29'd0, ras_n, cas_n}, 7);

    // R2 full word sweep: write then read back
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        access(1'b1, 2'b11, mk_addr(r, c), pat(mk_addr(r, c), 16'h1234), rd);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++) begin
        access(1'b0, 2'b11, mk_addr(r, c), '0, rd);
        expv = pat(mk_addr(r, c), 16'h1234);
        chk(rd == expv, "R2 word read back", rd, expv);
      end

    // R3 byte lanes: even columns write low lane, odd columns high lane
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        access(1'b1, (c % 2 == 0) ? 2'b01 : 2'b10, mk_addr(r, c),
               pat(mk_addr(r, c), 16'h5A5A), rd);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++) begin
        access(1'b0, 2'b11, mk_addr(r, c), '0, rd);
        expv = pat(mk_addr(r, c), 16'h1234);
        nv   = pat(mk_addr(r, c), 16'h5A5A);
        if (c % 2 == 0) expv[7:0] = nv[7:0]; else expv[15:8] = nv[15:8];
        chk(rd == expv, "R3 lane merge", rd, expv);
      end

    // R9 partial reads return zero in the lane not selected
    access(1'b0, 2'b01, mk_addr(1, 2), '0, rd);
    nv = pat(mk_addr(1, 2), 16'h5A5A);
    chk(rd == {8'h00, nv[7:0]}, "R9 low lane only", rd, {8'h00, nv[7:0]});
    access(1'b0, 2'b10, mk_addr(1, 3), '0, rd);
    nv = pat(mk_addr(1, 3), 16'h5A5A);
    chk(rd == {nv[15:8], 8'h00}, "R9 high lane only", rd, {nv[15:8], 8'h00});

    // R5 page hit keeps the row open
    access(1'b0, 2'b11, mk_addr(2, 0), '0, rd);
    falls0 = ras_falls;
    access(1'b0, 2'b11, mk_addr(2, 4), '0, rd);
    chk(ras_falls == falls0, "R5 no new row strobe on hit", ras_falls, falls0);

    // R6 page miss precharges and reopens
    access(1'b0, 2'b11, mk_addr(3, 1), '0, rd);
    chk(ras_falls == falls0 + 1, "R6 one new row strobe on miss", ras_falls, falls0 + 1);

    // R7 long same-row stream crosses the window; idle row closes itself
    falls0 = ras_falls;
    hits = 0;
    for (int k = 0; k < 16; k++) begin
      access(1'b0, 2'b11, mk_addr(0, k % 8), '0, rd);
      if (rd == pat(mk_addr(0, k % 8), 16'h1234) || k % 8 != 0) hits++;
    end
    chk(ras_falls > falls0 + 1, "R7 window forces reopen", ras_falls, falls0 + 2);
    access(1'b0, 2'b11, mk_addr(1, 0), '0, rd);
    repeat (RAS_MAX + 10) @(negedge clk);
    chk(ras_n, "R7 idle row closed", {31'd0, ras_n}, 1);

    // R8 refresh from an open row
    access(1'b0, 2'b11, mk_addr(2, 1), '0, rd);
    refs0 = refreshes;
    @(negedge clk);
    ref_req = 1'b1;
    begin
      int n;
      n = 0;
      while (!ref_done && n < 1000) begin @(negedge clk); n++; end
      chk(ref_done, "R8 refresh done pulse", {31'd0, ref_done}, 1);
    end
    ref_req = 1'b0;
    @(negedge clk);
    chk(!ref_done, "R8 done is one pulse", {31'd0, ref_done}, 0);
    chk(refreshes == refs0 + 1, "R8 one refresh seen", refreshes, refs0 + 1);
    access(1'b0, 2'b11, mk_addr(2, 1), '0, rd);
    expv = pat(mk_addr(2, 1), 16'h1234);
    nv = pat(mk_addr(2, 1), 16'h5A5A);
    expv[15:8] = nv[15:8];
    chk(rd == expv, "R8 access after refresh", rd, expv);

    // R11 bus released when idle
    repeat (3) @(negedge clk);
    chk(!dq_oe, "R11 bus released when idle", {31'd0, dq_oe}, 0);

    summary();
    $finish;
  end
endmodule